// File: doc/BRIEF.md
# Packed-Pixel SIMD Arithmetic Unit

This block applies one arithmetic operation to every pixel packed into a 32-bit word. The word is split into independent lanes of 2, 4, 8 or 16 bits, giving 16, 8, 4 or 2 lanes. The lane width and the operation are chosen per transfer. Each lane's carry, borrow, clamp and halving stay inside that lane. Pixels are treated as unsigned.

A caller presents two source words, a lane-width select, an operation code and a valid strobe. The result is registered and appears one cycle later with its own valid flag. The available operations are wrapping add, wrapping subtract, average, saturating add and saturating subtract. Unused operation codes pass source A through unchanged.

Top module: `pix_simd_unit`

## Requirements
- R1: While rst_ni is low, result_o and valid_o are zero.
- R2: valid_o equals valid_i as sampled at the previous rising clock edge.
- R3: result_o loads only on a clock edge where valid_i is high. Otherwise it holds its value, whatever the other inputs do.
- R4: lane_w_i selects the lane width: 0 = 2 bits, 1 = 4 bits, 2 = 8 bits, 3 = 16 bits. Lane k occupies bits [k*W +: W] of every word.
- R5: op_i = 0 (add) gives (a+b) mod 2^W per lane. No carry enters the neighbouring lane.
- R6: op_i = 1 (subtract) gives (a-b) mod 2^W per lane. No borrow leaves the lane.
- R7: op_i = 2 (average) gives (a+b)>>1 per lane. The sum is formed with its full W+1 bits and truncated.
- R8: op_i = 3 (saturating add) gives a+b per lane, clamped to all-ones when the sum exceeds 2^W-1.
- R9: op_i = 4 (saturating subtract) gives a-b per lane, clamped to zero when b > a.
- R10: op_i = 5, 6 or 7 loads src_a_i unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operands valid this cycle |
| lane_w_i | input | 2 | Lane width select |
| op_i | input | 3 | Operation select |
| src_a_i | input | 32 | Packed source A |
| src_b_i | input | 32 | Packed source B |
| result_o | output | 32 | Packed result, registered |
| valid_o | output | 1 | Result valid, one cycle after valid_i |

## Verification
Some vectors place an overflowing lane directly below a lane that should stay unchanged, so any carry or borrow crossing a lane boundary shows up. One fixed operand pair is run through all four lane widths: the four distinct results show that the lane boundaries move with the select. Vectors for the saturating operations mix clamping lanes with non-clamping lanes, and vectors for average use all-ones lanes, so a missing ninth sum bit or a missing clamp stands apart from a correct one. A sweep over every operation code and width is compared against a per-lane integer model. Idle cycles with changed inputs then confirm that the result holds.

// File: rtl/pix_simd_pkg.sv
package pix_simd_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned N_WIDTH = 4;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AVG  = 3'd2,
    OP_SADD = 3'd3,
    OP_SSUB = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    LW_2  = 2'd0,
    LW_4  = 2'd1,
    LW_8  = 2'd2,
    LW_16 = 2'd3
  } lane_w_e;
endpackage

// File: rtl/pix_lane_alu.sv
module pix_lane_alu
  import pix_simd_pkg::*;
#(
  parameter int unsigned LW = 8
) (
  input  op_e           op_i,
  input  logic [LW-1:0] a_i,
  input  logic [LW-1:0] b_i,
  output logic [LW-1:0] res_o
);
  logic [LW:0] sum_w, dif_w;

  always_comb begin
    sum_w = {1'b0, a_i} + {1'b0, b_i};
    dif_w = {1'b0, a_i} - {1'b0, b_i};
    unique case (op_i)
      OP_ADD:  res_o = sum_w[LW-1:0];
      OP_SUB:  res_o = dif_w[LW-1:0];
      OP_AVG:  res_o = sum_w[LW:1];
      OP_SADD: res_o = sum_w[LW] ? '1 : sum_w[LW-1:0];
      OP_SSUB: res_o = dif_w[LW] ? '0 : dif_w[LW-1:0];
      default: res_o = a_i;
    endcase
  end

  // Lane-level invariants, checked against the operands
  always_comb begin
    if (op_i == OP_ADD)
      AST_ADD_INVERSE: assert (LW'(res_o - b_i) == a_i) else $error("add lane"); // R5
    if (op_i == OP_SUB)
      AST_SUB_INVERSE: assert (LW'(res_o + b_i) == a_i) else $error("sub lane"); // R6
    if (op_i == OP_AVG)
      AST_AVG_BOUND: assert ((res_o >= a_i || res_o >= b_i) &&
                             (res_o <= a_i || res_o <= b_i)) else $error("avg lane"); // R7
    if (op_i == OP_SADD)
      AST_SADD_NO_WRAP: assert (res_o >= a_i && res_o >= b_i) else $error("sadd lane"); // R8
    if (op_i == OP_SSUB)
      AST_SSUB_NO_WRAP: assert (res_o <= a_i) else $error("ssub lane"); // R9
  end
endmodule

// File: rtl/pix_lane_bank.sv
module pix_lane_bank
  import pix_simd_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned LW     = 8
) (
  input  op_e               op_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic [WORD_W-1:0] res_o
);
  localparam int unsigned N_LANE = WORD_W / LW;

  for (genvar k = 0; k < N_LANE; k++) begin : g_lane
    pix_lane_alu #(.LW(LW)) u_lane (
      .op_i  (op_i),
      .a_i   (a_i[k*LW +: LW]),
      .b_i   (b_i[k*LW +: LW]),
      .res_o (res_o[k*LW +: LW])
    );
  end
endmodule

// File: rtl/pix_simd_unit.sv
module pix_simd_unit
  import pix_simd_pkg::*;
#(
  parameter int unsigned WORD_W = DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        lane_w_i,
  input  logic [2:0]        op_i,
  input  logic [WORD_W-1:0] src_a_i,
  input  logic [WORD_W-1:0] src_b_i,
  output logic [WORD_W-1:0] result_o,
  output logic              valid_o
);
  op_e               op_w;
  logic [WORD_W-1:0] bank_res [N_WIDTH];
  logic [WORD_W-1:0] res_d, res_q;
  logic              vld_q;

  assign op_w = op_e'(op_i);

  // One bank per lane width; the select picks a finished bank
  for (genvar g = 0; g < N_WIDTH; g++) begin : g_bank
    pix_lane_bank #(.WORD_W(WORD_W), .LW(2 << g)) u_bank (
      .op_i  (op_w),
      .a_i   (src_a_i),
      .b_i   (src_b_i),
      .res_o (bank_res[g])
    );
  end

  assign res_d = bank_res[lane_w_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= valid_i;
      if (valid_i) res_q <= res_d;
    end
  end

  assign result_o = res_q;
  assign valid_o  = vld_q;

  AST_VALID_PIPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o) else $error("valid pipe"); // R2
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o) else $error("valid idle"); // R2
  AST_HOLD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o)) else $error("result hold"); // R3
  AST_PASS_THRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i > 3'd4) |=> result_o == $past(src_a_i)) else $error("pass"); // R10
  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (result_o == '0 && !valid_o)) else $error("reset"); // R1
endmodule

// File: tb/pix_simd_unit_bench.sv
module pix_simd_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  lane_w_i = '0;
  logic [2:0]  op_i = '0;
  logic [31:0] src_a_i = '0;
  logic [31:0] src_b_i = '0;
  logic [31:0] result_o;
  logic        valid_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  pix_simd_unit u_pix_simd_unit (
    .clk_i, .rst_ni, .valid_i, .lane_w_i, .op_i,
    .src_a_i, .src_b_i, .result_o, .valid_o
  );

  typedef struct packed {
    logic [1:0]  w;
    logic [2:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] e;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{2'd3, 3'd0, 32'h0001_FFFF, 32'h0001_0001, 32'h0002_0000, 8'd5},  // R5 16b wrap, no carry up
    '{2'd2, 3'd0, 32'hFF01_80FF, 32'h0101_8001, 32'h0002_0000, 8'd5},  // R5 8b
    '{2'd0, 3'd0, 32'hFFFF_FFFF, 32'h5555_5555, 32'h0000_0000, 8'd5},  // R5 2b
    '{2'd1, 3'd1, 32'h0000_0000, 32'h1111_1111, 32'hFFFF_FFFF, 8'd6},  // R6 4b borrow stays
    '{2'd3, 3'd1, 32'h0000_0005, 32'h0001_0007, 32'hFFFF_FFFE, 8'd6},  // R6 16b
    '{2'd2, 3'd2, 32'hFF00_FF10, 32'hFF00_0130, 32'hFF00_8020, 8'd7},  // R7 8b full carry
    '{2'd3, 3'd2, 32'hFFFF_0003, 32'h0001_0000, 32'h8000_0001, 8'd7},  // R7 16b
    '{2'd0, 3'd2, 32'hAAAA_AAAA, 32'hFFFF_FFFF, 32'hAAAA_AAAA, 8'd7},  // R7 2b
    '{2'd1, 3'd3, 32'hF0F0_8888, 32'h1111_8877, 32'hF1F1_FFFF, 8'd8},  // R8 4b mixed clamp
    '{2'd0, 3'd4, 32'h0000_FFFF, 32'h5555_5555, 32'h0000_AAAA, 8'd9},  // R9 2b
    '{2'd2, 3'd4, 32'h1080_FF05, 32'h2080_0106, 32'h0000_FE00, 8'd9},  // R9 8b
    '{2'd1, 3'd5, 32'h1234_5678, 32'hFFFF_FFFF, 32'h1234_5678, 8'd10}, // R10
    '{2'd3, 3'd7, 32'hDEAD_BEEF, 32'h0101_0101, 32'hDEAD_BEEF, 8'd10}, // R10
    '{2'd0, 3'd0, 32'h0000_00FF, 32'h0000_0001, 32'h0000_00FC, 8'd4},  // R4 same pair, 2b
    '{2'd1, 3'd0, 32'h0000_00FF, 32'h0000_0001, 32'h0000_00F0, 8'd4},  // R4 4b
    '{2'd2, 3'd0, 32'h0000_00FF, 32'h0000_0001, 32'h0000_0000, 8'd4},  // R4 8b
    '{2'd3, 3'd0, 32'h0000_00FF, 32'h0000_0001, 32'h0000_0100, 8'd4}   // R4 16b
  };

  function automatic logic [31:0] model(input logic [1:0] ws, input logic [2:0] op,
                                        input logic [31:0] a, input logic [31:0] b);
    longint w    = longint'(2) << ws;
    longint mask = (longint'(1) << w) - 1;
    longint r    = 0;
    for (longint i = 0; i < 32 / w; i++) begin
      longint x = (longint'(a) >> (i * w)) & mask;
      longint y = (longint'(b) >> (i * w)) & mask;
      longint z;
      case (op)
        3'd0: z = (x + y) & mask;
        3'd1: z = (x - y) & mask;
        3'd2: z = (x + y) / 2;
        3'd3: z = (x + y > mask) ? mask : x + y;
        3'd4: z = (x >= y) ? x - y : 0;
        default: z = x;
      endcase
      r = r | (z << (i * w));
    end
    return r[31:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Drive one valid transfer, check the registered result one cycle later
  task automatic run(input logic [1:0] w, input logic [2:0] op,
                     input logic [31:0] a, input logic [31:0] b,
                     input logic [31:0] e, input string req);
    @(negedge clk_i);
    valid_i = 1'b1; lane_w_i = w; op_i = op; src_a_i = a; src_b_i = b;
    @(negedge clk_i);
    valid_i = 1'b0;
    check(req, result_o, e);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] held;
    // R1: reset state with inputs active
    valid_i = 1'b1; src_a_i = 32'hFFFF_FFFF; op_i = 3'd5;
    repeat (3) @(negedge clk_i);
    check("R1", result_o, 32'h0);
    check("R1 valid", {31'd0, valid_o}, 32'd0);
    valid_i = 1'b0;
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++)
      run(VEC[i].w, VEC[i].op, VEC[i].a, VEC[i].b, VEC[i].e,
          $sformatf("R%0d vec%0d", VEC[i].req, i));

    // R2: valid_o follows valid_i by one cycle
    @(negedge clk_i);
    valid_i = 1'b1; lane_w_i = 2'd2; op_i = 3'd0; src_a_i = 32'h0102_0304; src_b_i = 32'h0101_0101;
    @(negedge clk_i);
    check("R2 high", {31'd0, valid_o}, 32'd1);
    check("R5 back-to-back", result_o, 32'h0203_0405);
    valid_i = 1'b0;
    @(negedge clk_i);
    check("R2 low", {31'd0, valid_o}, 32'd0);

    // R3: idle cycles with changed operands leave the result alone
    held = result_o;
    src_a_i = 32'hFFFF_FFFF; src_b_i = 32'hFFFF_FFFF; op_i = 3'd3; lane_w_i = 2'd0;
    repeat (3) @(negedge clk_i);
    check("R3 hold", result_o, held);
    check("R3 valid", {31'd0, valid_o}, 32'd0);

    // Sweep of all codes and widths against the lane model (R4..R10)
    for (int p = 0; p < 2; p++) begin
      for (int w = 0; w < 4; w++) begin
        for (int o = 0; o < 8; o++) begin
          logic [31:0] a = (p == 0) ? 32'h9C3F_70E1 : 32'h0F80_FF7F;
          logic [31:0] b = (p == 0) ? 32'h6AC5_91FE : 32'hF181_0180;
          run(w[1:0], o[2:0], a, b, model(w[1:0], o[2:0], a, b),
              $sformatf("R4 sweep w%0d op%0d", w, o));
        end
      end
    end

    // R1: asynchronous reset mid-run clears the register
    run(2'd3, 3'd5, 32'hCAFE_F00D, 32'h0, 32'hCAFE_F00D, "R10 pre-reset");
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R1 async", result_o, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    finish_run();
  end
endmodule